// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel NOR flash. After software has issued a program or erase command sequence, a single-cycle start request gives the block three things: a valid poll address, the datum that was programmed, and whether the operation is an erase. The block then reads the flash status byte over a simple request/valid read port. It repeats the read until bit 7 shows the true value or the timeout flag in bit 5 is raised. It then reports pass or fail.

Bit 7 and bit 5 of the status byte can change in the same read. For that reason, a raised timeout flag is not taken as failure at once. The block first makes one more read and looks at bit 7 again. Bit 7 can also settle out of step with the lower bits. So once bit 7 reads true, the block makes one final read and returns that byte as the valid array data. A parameterised limit on the number of plain poll reads forces a failure if the flash never finishes and never flags a timeout.

Top module: `flash_done_poller`

## Requirements
- R1: A start pulse sampled while the block is idle or done is accepted. It latches the poll address, the datum and the erase flag. In the next cycle `busy_o` is high and `done_o`, `pass_o`, `fail_o` and `data_o` are cleared to 0. A start pulse sampled while `busy_o` is high is ignored: the address and the outcome of the running job do not change.
- R2: While busy, `rd_req_o` stays high and `rd_addr_o` holds the latched poll address. A byte is taken only at a clock edge where both `rd_req_o` and `rd_valid_i` are high. `rd_req_o` is low whenever `busy_o` is low.
- R3: The expected value of status bit 7 is 1 for an erase (`start_erase_i`=1). For a program it is bit 7 of `start_data_i`.
- R4: When a read shows bit 7 equal to the expected value, the block makes exactly one more read. In the cycle after that read's handshake, `done_o` and `pass_o` go high and `data_o` holds that last byte.
- R5: When bit 7 differs from the expected value and bit 5 is 0, the block makes another poll read.
- R6: When bit 7 differs and bit 5 is 1, the block makes one recheck read. If bit 7 of the recheck matches, it continues as in R4. If not, `done_o` and `fail_o` go high in the cycle after the recheck handshake, and `data_o` holds the recheck byte.
- R7: After `MAX_POLLS` poll reads that each show bit 7 differing and bit 5 at 0, the block ends with `done_o` and `fail_o` high and `data_o` equal to the last byte read.
- R8: `done_o`, `pass_o`, `fail_o` and `data_o` hold their values until the next accepted start. While `done_o` is high, exactly one of `pass_o` and `fail_o` is high, and `busy_o` is low.
- R9: After reset, `busy_o`, `rd_req_o`, `done_o`, `pass_o` and `fail_o` are low and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle start request |
| start_addr_i | input | ADDR_W | Valid poll address for this job |
| start_data_i | input | 8 | Programmed datum (ignored for erase) |
| start_erase_i | input | 1 | 1 = erase job, 0 = program job |
| rd_req_o | output | 1 | Read request, held until the byte is accepted |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read byte valid |
| rd_data_i | input | 8 | Byte returned by the flash |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Job finished, held |
| pass_o | output | 1 | Job finished successfully, held |
| fail_o | output | 1 | Job finished with failure, held |
| data_o | output | 8 | Final byte of the job, held |

## Verification
The block registers every result once, so each output is due one clock edge after the edge that triggers it. `busy_o` and `rd_req_o` rise one edge after the start is sampled. `done_o`, `pass_o`/`fail_o` and `data_o` change one edge after the handshake of the deciding read. Two events trigger no result, and neither adds a cycle: a DQ5-driven recheck, and a plain poll read under the limit. The bench reference model steps through the same edges as the design. It takes the same sampled inputs, and its state is compared at the falling edge, halfway between updates. Each job also checks its outcome, its returned byte and its number of reads once `done_o` is seen. These jobs use several read latencies.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

  localparam int BYTE_W  = 8;
  localparam int DONE_BIT = 7;   // data-polling bit
  localparam int TMO_BIT  = 5;   // time-limit-exceeded flag

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_POLL  = 2'd1,
    PH_RECHK = 2'd2,
    PH_FINAL = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    V_AGAIN = 2'd0,
    V_TRUE  = 2'd1,
    V_FLAG  = 2'd2
  } verdict_t;

  // expected level of the polling bit once the operation is finished
  function automatic logic expect_dq7(input logic erase, input logic [BYTE_W-1:0] datum);
    return erase ? 1'b1 : datum[DONE_BIT];
  endfunction

  // classify one status byte against the expected polling level
  function automatic verdict_t classify(input logic [BYTE_W-1:0] sts, input logic exp_bit);
    if (sts[DONE_BIT] == exp_bit) return V_TRUE;
    if (sts[TMO_BIT])             return V_FLAG;
    return V_AGAIN;
  endfunction

endpackage

// File: rtl/fdp_poll_count.sv
module fdp_poll_count #(
  parameter int MAX_POLLS = 4096,
  localparam int CNT_W = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/fdp_seq.sv
module fdp_seq
  import fdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              erase_i,
  input  logic [BYTE_W-1:0] datum_i,
  input  logic              rd_valid_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  input  logic              last_i,
  output phase_t            phase_o,
  output logic              handshake_o,
  output logic              hit_o,
  output logic              flag_o,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              finish_o,
  output logic              fin_pass_o
);

  phase_t   phase_q, phase_d;
  logic     exp_q;
  verdict_t vd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      exp_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept_i) exp_q <= expect_dq7(erase_i, datum_i);
    end
  end

  assign vd          = classify(rd_byte_i, exp_q);
  assign handshake_o = rd_valid_i && (phase_q != PH_IDLE);
  assign hit_o       = handshake_o && (vd == V_TRUE);
  assign flag_o      = handshake_o && (vd == V_FLAG);

  always_comb begin
    phase_d    = phase_q;
    cnt_clr_o  = 1'b0;
    cnt_inc_o  = 1'b0;
    finish_o   = 1'b0;
    fin_pass_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept_i) begin
          phase_d   = PH_POLL;
          cnt_clr_o = 1'b1;
        end
      end
      PH_POLL: begin
        if (handshake_o) begin
          unique case (vd)
            V_TRUE:  phase_d = PH_FINAL;
            V_FLAG:  phase_d = PH_RECHK;
            default: begin
              if (last_i) begin
                phase_d  = PH_IDLE;
                finish_o = 1'b1;
              end else begin
                cnt_inc_o = 1'b1;
              end
            end
          endcase
        end
      end
      PH_RECHK: begin
        if (handshake_o) begin
          if (rd_byte_i[DONE_BIT] == exp_q) begin
            phase_d = PH_FINAL;
          end else begin
            phase_d  = PH_IDLE;
            finish_o = 1'b1;
          end
        end
      end
      PH_FINAL: begin
        if (handshake_o) begin
          phase_d    = PH_IDLE;
          finish_o   = 1'b1;
          fin_pass_o = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/fdp_req_port.sv
module fdp_req_port
  import fdp_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  phase_t            phase_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_q <= '0;
    else if (accept_i) addr_q <= addr_i;
  end

  assign rd_addr_o = addr_q;
  assign rd_req_o  = (phase_i != PH_IDLE);

endmodule

// File: rtl/fdp_result.sv
module fdp_result
  import fdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              finish_i,
  input  logic              fin_pass_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [BYTE_W-1:0] data_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
      data_o <= '0;
    end else if (accept_i) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
      data_o <= '0;
    end else if (finish_i) begin
      done_o <= 1'b1;
      pass_o <= fin_pass_i;
      fail_o <= !fin_pass_i;
      data_o <= byte_i;
    end
  end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fdp_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [7:0]        start_data_i,
  input  logic              start_erase_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [7:0]        data_o
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  // named internal events
  phase_t           phase_w;
  logic             accept_w;
  logic             handshake_w;
  logic             hit_w;
  logic             flag_w;
  logic             cnt_clr_w;
  logic             cnt_inc_w;
  logic             last_w;
  logic             finish_w;
  logic             fin_pass_w;
  logic [CNT_W-1:0] poll_cnt_w;

  assign accept_w = start_i && (phase_w == PH_IDLE);
  assign busy_o   = (phase_w != PH_IDLE);

  fdp_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_w),
    .erase_i     (start_erase_i),
    .datum_i     (start_data_i),
    .rd_valid_i  (rd_valid_i),
    .rd_byte_i   (rd_data_i),
    .last_i      (last_w),
    .phase_o     (phase_w),
    .handshake_o (handshake_w),
    .hit_o       (hit_w),
    .flag_o      (flag_w),
    .cnt_clr_o   (cnt_clr_w),
    .cnt_inc_o   (cnt_inc_w),
    .finish_o    (finish_w),
    .fin_pass_o  (fin_pass_w)
  );

  fdp_poll_count #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr_w),
    .inc_i  (cnt_inc_w),
    .cnt_o  (poll_cnt_w),
    .last_o (last_w)
  );

  fdp_req_port #(.ADDR_W(ADDR_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept_w),
    .addr_i    (start_addr_i),
    .phase_i   (phase_w),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o)
  );

  fdp_result u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept_w),
    .finish_i   (finish_w),
    .fin_pass_i (fin_pass_w),
    .byte_i     (rd_data_i),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .data_o     (data_o)
  );

endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
  parameter int ADDR_W    = 17,
  parameter int MAX_POLLS = 4096,
  localparam int CNT_W = $clog2(MAX_POLLS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic [7:0]        data_o,
  input logic              accept_w,
  input logic              finish_w,
  input logic [CNT_W-1:0]  poll_cnt_w
);

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (busy_o && !done_o && !pass_o && !fail_o));

  assert_ignore_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !(rd_req_o && rd_valid_i)) |=> (busy_o && $stable(rd_addr_o)));

  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

  assert_done_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(rd_req_o && rd_valid_i));

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt_w < CNT_W'(MAX_POLLS));

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((pass_o ^ fail_o) && !busy_o));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(data_o)));

  assert_finish_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finish_w |=> !busy_o);

endmodule

bind flash_done_poller fdp_checker #(.ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_valid_i (rd_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o),
  .data_o     (data_o),
  .accept_w   (accept_w),
  .finish_w   (finish_w),
  .poll_cnt_w (poll_cnt_w)
);

// File: tb/flash_done_poller_test.sv
`timescale 1ns/1ps
module flash_done_poller_test;

  localparam int AW   = 17;
  localparam int MAXP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [7:0]    start_data_i = '0;
  logic          start_erase_i = 1'b0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_valid_i = 1'b0;
  logic [7:0]    rd_data_i = '0;
  logic          busy_o, done_o, pass_o, fail_o;
  logic [7:0]    data_o;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  int reads = 0;
  int lat = 0;
  logic [7:0] resp_q[$];

  always #2.5 clk = ~clk;   // 200 MHz

  flash_done_poller #(.ADDR_W(AW), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .start_data_i(start_data_i), .start_erase_i(start_erase_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
    .fail_o(fail_o), .data_o(data_o)
  );

  // ---------------- behavioural reference model ----------------
  int          m_stage = 0;     // 0 none, 1 polling, 2 recheck, 3 final read
  int          m_polls = 0;
  logic        m_exp = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic        m_done = 0, m_pass = 0, m_fail = 0;
  logic [7:0]  m_data = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage = 0; m_polls = 0; m_exp = 0; m_addr = '0;
      m_done = 0; m_pass = 0; m_fail = 0; m_data = 0;
    end else if (m_stage == 0) begin
      if (start_i) begin
        m_stage = 1; m_polls = 0;
        m_exp  = start_erase_i ? 1'b1 : start_data_i[7];
        m_addr = start_addr_i;
        m_done = 0; m_pass = 0; m_fail = 0; m_data = 0;
      end
    end else if (rd_valid_i) begin
      if (m_stage == 3) begin
        m_stage = 0; m_done = 1; m_pass = 1; m_data = rd_data_i;
      end else if (rd_data_i[7] == m_exp) begin
        m_stage = 3;
      end else if (m_stage == 2) begin
        m_stage = 0; m_done = 1; m_fail = 1; m_data = rd_data_i;
      end else if (rd_data_i[5]) begin
        m_stage = 2;
      end else begin
        m_polls++;
        if (m_polls >= MAXP) begin
          m_stage = 0; m_done = 1; m_fail = 1; m_data = rd_data_i;
        end
      end
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // compare every clock, half a period after the update edge
  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R1", "busy", busy_o, m_stage != 0);
      cmp("R2", "rd_req", rd_req_o, m_stage != 0);
      if (m_stage != 0) cmp("R2", "rd_addr", rd_addr_o, m_addr);
      cmp("R8", "done", done_o, m_done);
      cmp("R4", "pass", pass_o, m_pass);
      cmp("R6", "fail", fail_o, m_fail);
      cmp("R4", "data", data_o, m_data);
    end
  end

  // ---------------- flash responder ----------------
  initial begin
    int wait_ctr;
    wait_ctr = 0;
    forever begin
      @(negedge clk);
      if (rd_valid_i) begin
        rd_valid_i = 1'b0;
        wait_ctr   = lat;
      end else if (rd_req_o) begin
        if (wait_ctr > 0) wait_ctr--;
        else begin
          rd_valid_i = 1'b1;
          rd_data_i  = (resp_q.size() != 0) ? resp_q.pop_front() : 8'h00;
          reads++;
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        miscompares++;
        $display("FAIL R9 watchdog actual=%0d expected<=%0d", cycles, 20000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  task automatic pulse_start(input logic [AW-1:0] a, input logic [7:0] d, input logic er);
    @(negedge clk);
    start_addr_i = a; start_data_i = d; start_erase_i = er; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_job(input string req, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic er, input int l, input bit exp_pass,
                         input logic [7:0] exp_data, input int exp_reads, input bit poke);
    lat = l;
    reads = 0;
    pulse_start(a, d, er);
    if (poke) begin
      // start while busy must be ignored (R1)
      @(negedge clk);
      start_addr_i = ~a; start_data_i = ~d; start_erase_i = ~er; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    cmp(req, "outcome pass", pass_o, exp_pass);
    cmp(req, "outcome fail", fail_o, !exp_pass);
    cmp(req, "final byte", data_o, exp_data);
    cmp(req, "read count", reads, exp_reads);
    repeat (4) @(negedge clk);
    cmp("R8", "held done", done_o, 1);
    cmp("R8", "held byte", data_o, exp_data);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    cmp("R9", "reset busy", busy_o, 0);
    cmp("R9", "reset rd_req", rd_req_o, 0);
    cmp("R9", "reset done", done_o | pass_o | fail_o, 0);
    cmp("R9", "reset data", data_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4/R5/R3: program, expected bit7=1, two plain misses, extra read returns new byte
    resp_q = '{8'h05, 8'h05, 8'h85, 8'hA5};
    run_job("R4", 17'h1_0203, 8'hA5, 1'b0, 0, 1'b1, 8'hA5, 4, 1'b0);

    // R3: program with bit7=0, latency 2, start poked while busy (R1)
    resp_q = '{8'h9C, 8'h3C, 8'h3C};
    run_job("R3", 17'h0_4444, 8'h3C, 1'b0, 2, 1'b1, 8'h3C, 3, 1'b1);

    // R6: erase, DQ5 raised, recheck shows completion
    resp_q = '{8'h00, 8'h20, 8'hFF, 8'hFF};
    run_job("R6", 17'h1_F000, 8'h00, 1'b1, 1, 1'b1, 8'hFF, 4, 1'b0);

    // R6: DQ7 and DQ5 change together on the same read
    resp_q = '{8'hA0, 8'h11, 8'h11};
    run_job("R6", 17'h0_0010, 8'h11, 1'b0, 0, 1'b1, 8'h11, 3, 1'b0);

    // R6: DQ5 raised and recheck still mismatching -> fail
    resp_q = '{8'h20, 8'h20};
    run_job("R6", 17'h0_8000, 8'h80, 1'b0, 3, 1'b0, 8'h20, 2, 1'b1);

    // R7: erase never finishes, no flag -> fail after MAXP reads
    resp_q = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    run_job("R7", 17'h1_2345, 8'h00, 1'b1, 1, 1'b0, 8'h05, MAXP, 1'b0);

    // R1: start from the done state clears results next cycle
    resp_q = '{8'h7F, 8'h7E};
    lat = 0;
    pulse_start(17'h0_0001, 8'h7E, 1'b0);
    cmp("R1", "cleared done", done_o, 0);
    cmp("R1", "busy after start", busy_o, 1);
    while (!done_o) @(negedge clk);
    cmp("R5", "pass after extra read", pass_o, 1);
    cmp("R4", "extra byte", data_o, 8'h7E);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule